// File: doc/BRIEF.md
# Output Driver Init and Diagnostic Poller

This controller supervises a four-channel low-side output driver that is reached through a separate serial frame engine. After a start request it holds the driver in reset, releases it, and checks its identity register. It then runs a fixed configuration program. This program writes the configuration register, performs two diagnostic passes (read three diagnostic registers, then write zero to each), and writes the global status register to enable the outputs. Only after that does it raise the enable pin.

Once it is ready, the controller wakes every poll period. Each wake-up runs one diagnostic pass and then reads the global status register. A status bit that reports a power-on reset or a communication watchdog event is counted, and the configuration program is rerun without a new identity check. The diagnostic codes from every non-discarded pass are decoded into five registered fault flags per channel.

The frame engine sees one frame at a time: a single-cycle command pulse that carries a write flag, a 4-bit register address and 8 data bits. It answers with a single-cycle response that carries 8 data bits and an error flag. The reply to a frame carries the contents of the register addressed by the previous frame, so every register read is sent as two identical frames. Delays are counted in clock cycles through a parameter for one millisecond.

Top module: `odrv_sup`

## Requirements
- R1: After reset the state output is DISABLED (code 0), `drv_rst_n` and `drv_en` are low, all fault flags and counters are zero, and no frame is issued until `start` is seen.
- R2: On `start` in DISABLED the state becomes WAIT_INIT (code 1). `drv_rst_n` stays low for `MS_CYC` cycles and then rises, and the first frame follows a further `MS_CYC` cycles later.
- R3: A register read is two identical read frames, and only the second reply is used. The identity read (address 0x8) must return 0xB1; any other value gives state FAILED (code 3).
- R4: The init frame order is: identity read, write 0x0F to address 0x1, two diagnostic passes, then write 0x80 to address 0x7. The state then becomes READY (code 2). `drv_en` is high only in READY, and it rises after the last init frame.
- R5: A diagnostic pass reads addresses 0x4, 0x5 and 0x6 in that order, then writes 0x00 to 0x4, 0x5 and 0x6 in that order. The codes of the first init pass never reach the fault flags.
- R6: In READY, a poll starts `POLL_MS*MS_CYC` cycles after the previous sequence ends. A poll is a diagnostic pass followed by a read of address 0x7. No frames are issued in DISABLED or FAILED.
- R7: In a status read, bit 0 set increments `por_cnt` and bit 2 set increments `wdg_cnt`. Either bit restarts the init program at the config write, with no identity read, while the state stays READY.
- R8: The on-state codes are 3-bit fields: channels 0 and 1 at bits [2:0] and [5:3] of address 0x4, channels 2 and 3 at the same bits of address 0x5. Code 2 sets `flt_sbat`, code 3 sets `flt_otemp` and `flt_ovl`, code 4 sets `flt_ovl`, and code 5 sets `flt_otemp`.
- R9: The off-state codes are 2-bit fields of address 0x6 at bits [1:0], [3:2], [5:4] and [7:6] for channels 0 to 3. Code 2 sets `flt_open` and code 3 sets `flt_sgnd`.
- R10: An error response in WAIT_INIT gives FAILED with `drv_en` low. FAILED issues no frames and ignores `start` until reset.
- R11: An error response in READY increments `err_cnt`, abandons the current poll and keeps the state READY. The next poll starts again with the diagnostic pass.
- R12: `cmd_valid` is a one-cycle pulse, and no new frame is issued before the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin power-up from DISABLED |
| cmd_valid | output | 1 | One-cycle frame request |
| cmd_wr | output | 1 | Frame is a write |
| cmd_addr | output | 4 | Register address of the frame |
| cmd_data | output | 8 | Write data (zero for reads) |
| rsp_valid | input | 1 | One-cycle frame response |
| rsp_data | input | 8 | Reply data (register addressed by previous frame) |
| rsp_err | input | 1 | Frame failed (parity or transport) |
| drv_rst_n | output | 1 | Driver reset pin, active low |
| drv_en | output | 1 | Driver output enable pin |
| state | output | 2 | 0 DISABLED, 1 WAIT_INIT, 2 READY, 3 FAILED |
| flt_sbat | output | 4 | Per-channel short to battery |
| flt_otemp | output | 4 | Per-channel overtemperature |
| flt_ovl | output | 4 | Per-channel overload |
| flt_open | output | 4 | Per-channel open load |
| flt_sgnd | output | 4 | Per-channel short to ground |
| por_cnt | output | CW | Power-on reset events seen |
| wdg_cnt | output | CW | Watchdog events seen |
| err_cnt | output | CW | Frame errors while READY |

## Verification
The assertions assume that the frame engine raises `rsp_valid` only while a frame is outstanding, for exactly one cycle per frame. They also assume that `start` is meaningful only in DISABLED. The bench's engine model answers every command exactly once after a fixed two-cycle latency. It raises the error flag only on the response it was told to corrupt. Its reply data always carries the register named by the previous frame, so a design that used the first reply of a read pair would see stale values.

// File: rtl/odrv_pkg.sv
package odrv_pkg;

  typedef enum logic [1:0] {
    ST_DISABLED  = 2'd0,
    ST_WAIT_INIT = 2'd1,
    ST_READY     = 2'd2,
    ST_FAILED    = 2'd3
  } drv_state_e;

  typedef struct packed {
    logic       wr;
    logic [3:0] addr;
    logic [7:0] data;
  } frame_t;

  // device register addresses (decoded by the driver)
  localparam logic [3:0] A_CFG  = 4'h1;
  localparam logic [3:0] A_DON0 = 4'h4;
  localparam logic [3:0] A_DON1 = 4'h5;
  localparam logic [3:0] A_DOFF = 4'h6;
  localparam logic [3:0] A_GST  = 4'h7;
  localparam logic [3:0] A_ID   = 4'h8;
  localparam logic [7:0] ID_VAL = 8'hB1;

  // program step indexes
  localparam int PASS_LEN = 6;
  localparam logic [4:0] S_ID   = 5'd0;
  localparam logic [4:0] S_CFG  = 5'd1;
  localparam logic [4:0] S_D1   = 5'd2;
  localparam logic [4:0] S_D2   = 5'd8;
  localparam logic [4:0] S_GST  = 5'd14;
  localparam logic [4:0] S_PD   = 5'd15;
  localparam logic [4:0] S_STAT = 5'd21;

  function automatic frame_t step_frame(input logic [4:0] s);
    frame_t     f;
    logic [4:0] k;
    f = '0;
    k = '0;
    if (s == S_ID) begin
      f.addr = A_ID;
    end else if (s == S_CFG) begin
      f.wr = 1'b1; f.addr = A_CFG; f.data = 8'h0F;
    end else if (s == S_GST) begin
      f.wr = 1'b1; f.addr = A_GST; f.data = 8'h80;
    end else if (s >= S_STAT) begin
      f.addr = A_GST;
    end else begin
      if (s >= S_PD)      k = s - S_PD;
      else if (s >= S_D2) k = s - S_D2;
      else                k = s - S_D1;
      if (k < 5'd3) begin
        f.addr = A_DON0 + k[3:0];
      end else begin
        f.wr   = 1'b1;
        f.addr = A_DON0 + k[3:0] - 4'd3;
      end
    end
    return f;
  endfunction

endpackage

// File: rtl/odrv_tick.sv
module odrv_tick #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          done
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == TW'(1));
endmodule

// File: rtl/odrv_fault_dec.sv
module odrv_fault_dec #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           upd,
  input  logic [7:0]     on01,
  input  logic [7:0]     on23,
  input  logic [7:0]     offc,
  output logic [NCH-1:0] sbat,
  output logic [NCH-1:0] otemp,
  output logic [NCH-1:0] ovl,
  output logic [NCH-1:0] open,
  output logic [NCH-1:0] sgnd
);
  logic [NCH-1:0] n_sbat, n_otemp, n_ovl, n_open, n_sgnd;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int OS = 3 * (c % 2);
    logic [7:0] src;
    logic [2:0] oc;
    logic [1:0] fc;
    assign src = (c < 2) ? on01 : on23;
    assign oc  = src[OS +: 3];
    assign fc  = offc[2*c +: 2];
    assign n_sbat[c]  = (oc == 3'd2);
    assign n_otemp[c] = (oc == 3'd3) || (oc == 3'd5);
    assign n_ovl[c]   = (oc == 3'd3) || (oc == 3'd4);
    assign n_open[c]  = (fc == 2'd2);
    assign n_sgnd[c]  = (fc == 2'd3);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sbat <= '0; otemp <= '0; ovl <= '0; open <= '0; sgnd <= '0;
    end else if (upd) begin
      sbat <= n_sbat; otemp <= n_otemp; ovl <= n_ovl;
      open <= n_open; sgnd <= n_sgnd;
    end
  end
endmodule

// File: rtl/odrv_sup.sv
module odrv_sup
  import odrv_pkg::*;
#(
  parameter int MS_CYC  = 125000,
  parameter int POLL_MS = 100,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          cmd_valid,
  output logic          cmd_wr,
  output logic [3:0]    cmd_addr,
  output logic [7:0]    cmd_data,
  input  logic          rsp_valid,
  input  logic [7:0]    rsp_data,
  input  logic          rsp_err,
  output logic          drv_rst_n,
  output logic          drv_en,
  output logic [1:0]    state,
  output logic [3:0]    flt_sbat,
  output logic [3:0]    flt_otemp,
  output logic [3:0]    flt_ovl,
  output logic [3:0]    flt_open,
  output logic [3:0]    flt_sgnd,
  output logic [CW-1:0] por_cnt,
  output logic [CW-1:0] wdg_cnt,
  output logic [CW-1:0] err_cnt
);
  localparam int NCH      = 4;
  localparam int POLL_CYC = MS_CYC * POLL_MS;
  localparam int TW       = $clog2(POLL_CYC + 1);
  localparam logic [4:0] D1_END = S_D1 + 5'(PASS_LEN - 1);
  localparam logic [4:0] D2_END = S_D2 + 5'(PASS_LEN - 1);
  localparam logic [4:0] PD_END = S_PD + 5'(PASS_LEN - 1);

  typedef enum logic [2:0] {
    PH_OFF, PH_RLO, PH_RHI, PH_SEND, PH_WAIT, PH_SLEEP, PH_HALT
  } phase_e;

  phase_e        ph;
  drv_state_e    st;
  logic [4:0]    s;
  logic          sub;
  logic          t_load, t_done, pub;
  logic [TW-1:0] t_val;
  logic [7:0]    d_on01, d_on23, d_off;
  frame_t        cur;

  assign cur   = step_frame(s);
  assign state = st;

  odrv_tick #(.TW(TW)) u_tick (
    .clk(clk), .rst(rst), .load(t_load), .val(t_val), .done(t_done)
  );

  odrv_fault_dec #(.NCH(NCH)) u_dec (
    .clk(clk), .rst(rst), .upd(pub),
    .on01(d_on01), .on23(d_on23), .offc(d_off),
    .sbat(flt_sbat), .otemp(flt_otemp), .ovl(flt_ovl),
    .open(flt_open), .sgnd(flt_sgnd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_OFF; st <= ST_DISABLED; s <= '0; sub <= 1'b0;
      cmd_valid <= 1'b0; cmd_wr <= 1'b0; cmd_addr <= '0; cmd_data <= '0;
      drv_rst_n <= 1'b0; drv_en <= 1'b0;
      t_load <= 1'b0; t_val <= '0; pub <= 1'b0;
      d_on01 <= '0; d_on23 <= '0; d_off <= '0;
      por_cnt <= '0; wdg_cnt <= '0; err_cnt <= '0;
    end else begin
      cmd_valid <= 1'b0;
      t_load    <= 1'b0;
      pub       <= 1'b0;
      case (ph)
        PH_OFF: if (start) begin
          st <= ST_WAIT_INIT; ph <= PH_RLO;
          t_load <= 1'b1; t_val <= TW'(MS_CYC);
        end
        PH_RLO: if (t_done) begin
          drv_rst_n <= 1'b1; ph <= PH_RHI;
          t_load <= 1'b1; t_val <= TW'(MS_CYC);
        end
        PH_RHI: if (t_done) begin
          s <= S_ID; sub <= 1'b0; ph <= PH_SEND;
        end
        PH_SEND: begin
          cmd_valid <= 1'b1;
          cmd_wr    <= cur.wr;
          cmd_addr  <= cur.addr;
          cmd_data  <= cur.data;
          ph        <= PH_WAIT;
        end
        PH_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            sub <= 1'b0;
            if (st == ST_WAIT_INIT) begin
              st <= ST_FAILED; drv_en <= 1'b0; ph <= PH_HALT;
            end else begin
              err_cnt <= err_cnt + 1'b1; ph <= PH_SLEEP;
              t_load <= 1'b1; t_val <= TW'(POLL_CYC);
            end
          end else if (!cur.wr && !sub) begin
            sub <= 1'b1; ph <= PH_SEND;
          end else begin
            sub <= 1'b0;
            if (!cur.wr) begin
              case (cur.addr)
                A_DON0:  d_on01 <= rsp_data;
                A_DON1:  d_on23 <= rsp_data;
                A_DOFF:  d_off  <= rsp_data;
                default: ;
              endcase
            end
            if (s == D2_END || s == PD_END) pub <= 1'b1;
            if (s == S_ID) begin
              if (rsp_data == ID_VAL) begin
                s <= S_CFG; ph <= PH_SEND;
              end else begin
                st <= ST_FAILED; ph <= PH_HALT;
              end
            end else if (s == S_GST) begin
              st <= ST_READY; drv_en <= 1'b1; ph <= PH_SLEEP;
              t_load <= 1'b1; t_val <= TW'(POLL_CYC);
            end else if (s == S_STAT) begin
              if (rsp_data[0]) por_cnt <= por_cnt + 1'b1;
              if (rsp_data[2]) wdg_cnt <= wdg_cnt + 1'b1;
              if (rsp_data[0] || rsp_data[2]) begin
                s <= S_CFG; ph <= PH_SEND;
              end else begin
                ph <= PH_SLEEP;
                t_load <= 1'b1; t_val <= TW'(POLL_CYC);
              end
            end else if (s == D1_END) begin
              s <= S_D2; ph <= PH_SEND;
            end else begin
              s <= s + 5'd1; ph <= PH_SEND;
            end
          end
        end
        PH_SLEEP: if (t_done) begin
          s <= S_PD; sub <= 1'b0; ph <= PH_SEND;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/odrv_sup_chk.sv
module odrv_sup_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          rsp_valid,
  input logic          drv_rst_n,
  input logic          drv_en,
  input logic [1:0]    state,
  input logic [CW-1:0] err_cnt
);
  p_en_only_ready_r4: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> state == 2'd2);

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> !cmd_valid);

  p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd0) |-> (!cmd_valid && !drv_rst_n));

  p_failed_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd3) |=> (state == 2'd3 && !cmd_valid && !drv_en));

  p_err_needs_rsp_r11: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |=> $stable(err_cnt));

  p_ready_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (state == 2'd2) |=> (state == 2'd2 || state == 2'd3));
endmodule

bind odrv_sup odrv_sup_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .rsp_valid(rsp_valid),
  .drv_rst_n(drv_rst_n), .drv_en(drv_en), .state(state), .err_cnt(err_cnt)
);

// File: tb/odrv_sup_bench.sv
`timescale 1ns/1ps
module odrv_sup_bench;
  localparam int MS   = 10;
  localparam int PMS  = 4;
  localparam int POLL = MS * PMS;
  localparam int CW   = 8;
  localparam int NEXP = 33;
  // {wr, addr, data}: init (22 frames) then one plain poll (11 frames)
  localparam logic [12:0] EXP [NEXP] = '{
    13'h0800, 13'h0800, 13'h110F,
    13'h0400, 13'h0400, 13'h0500, 13'h0500, 13'h0600, 13'h0600,
    13'h1400, 13'h1500, 13'h1600,
    13'h0400, 13'h0400, 13'h0500, 13'h0500, 13'h0600, 13'h0600,
    13'h1400, 13'h1500, 13'h1600,
    13'h1780,
    13'h0400, 13'h0400, 13'h0500, 13'h0500, 13'h0600, 13'h0600,
    13'h1400, 13'h1500, 13'h1600,
    13'h0700, 13'h0700
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic cmd_valid, cmd_wr, drv_rst_n, drv_en;
  logic [3:0] cmd_addr;
  logic [7:0] cmd_data;
  logic rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [7:0] rsp_data = '0;
  logic [1:0] state;
  logic [3:0] f_sb, f_ot, f_ol, f_op, f_sg;
  logic [CW-1:0] por_cnt, wdg_cnt, err_cnt;

  always #4 clk = ~clk;

  odrv_sup #(.MS_CYC(MS), .POLL_MS(PMS), .CW(CW)) u_odrv_sup (
    .clk(clk), .rst(rst), .start(start),
    .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .drv_rst_n(drv_rst_n), .drv_en(drv_en), .state(state),
    .flt_sbat(f_sb), .flt_otemp(f_ot), .flt_ovl(f_ol), .flt_open(f_op), .flt_sgnd(f_sg),
    .por_cnt(por_cnt), .wdg_cnt(wdg_cnt), .err_cnt(err_cnt)
  );

  int checks = 0, fails = 0, cyc = 0, nfr = 0, lat = 0;
  logic [7:0]  mregs [16];
  logic [3:0]  prev_addr;
  logic [7:0]  pend;
  logic        inj = 1'b0;
  logic [12:0] lg  [160];
  int          lt  [160];
  logic        len [160];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // frame engine model: reply carries register named by the previous frame
  always @(negedge clk) begin
    cyc++;
    rsp_valid = 1'b0;
    rsp_err   = 1'b0;
    if (lat > 0) begin
      lat--;
      if (lat == 0) begin
        rsp_valid = 1'b1; rsp_data = pend; rsp_err = inj; inj = 1'b0;
      end
    end
    if (cmd_valid) begin
      if (nfr < 160) begin
        lg[nfr] = {cmd_wr, cmd_addr, cmd_data}; lt[nfr] = cyc; len[nfr] = drv_en;
      end
      nfr++;
      pend = mregs[prev_addr];
      prev_addr = cmd_addr;
      if (cmd_wr) mregs[cmd_addr] = cmd_data;
      lat = 2;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; inj = 1'b0;
    for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
    prev_addr = 4'h0;
    repeat (3) @(negedge clk);
    nfr = 0; lat = 0;
    rst = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_frames(input int n);
    while (nfr < n) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  initial begin : main
    int base;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(state == 2'd0, "R1 state", state, 0);
    chk(!drv_rst_n && !drv_en, "R1 pins", {drv_rst_n, drv_en}, 0);
    chk({f_sb, f_ot, f_ol, f_op, f_sg} == '0, "R1 flags", {f_sb, f_ot, f_ol, f_op, f_sg}, 0);
    chk({por_cnt, wdg_cnt, err_cnt} == '0, "R1 counters", {por_cnt, wdg_cnt, err_cnt}, 0);
    repeat (30) @(negedge clk);
    chk(nfr == 0, "R1 no frames before start", nfr, 0);

    // R2 power-up timing; junk in diag registers for R5
    mregs[8] = 8'hB1; mregs[4] = 8'hFF; mregs[5] = 8'hFF; mregs[6] = 8'hFF;
    pulse_start();
    repeat (4) @(negedge clk);
    chk(state == 2'd1, "R2 state wait_init", state, 1);
    chk(!drv_rst_n, "R2 reset held", drv_rst_n, 0);
    repeat (10) @(negedge clk);
    chk(drv_rst_n, "R2 reset released", drv_rst_n, 1);
    chk(nfr == 0, "R2 second wait before frames", nfr, 0);

    // R3 R4 R5 init sequence, table walk
    wait_frames(22);
    for (int i = 0; i < 22; i++)
      chk(lg[i] == EXP[i], $sformatf("R4 init frame %0d", i), lg[i], EXP[i]);
    chk(state == 2'd2 && drv_en, "R4 ready with enable", {state, drv_en}, 5);
    chk(!len[21], "R4 enable low during last init frame", len[21], 0);
    chk({f_sb, f_ot, f_ol, f_op, f_sg} == '0, "R5 first pass discarded",
        {f_sb, f_ot, f_ol, f_op, f_sg}, 0);
    begin
      int mg = 1000;
      for (int i = 1; i < 22; i++) if (lt[i] - lt[i-1] < mg) mg = lt[i] - lt[i-1];
      chk(mg >= 3, "R12 one frame outstanding", mg, 3);
    end

    // R8 R9 decode on first poll
    mregs[4] = 8'h1A;  // ch0 code2, ch1 code3
    mregs[5] = 8'h2C;  // ch2 code4, ch3 code5
    mregs[6] = 8'h8E;  // ch0 2, ch1 3, ch2 0, ch3 2
    wait_frames(33);
    for (int i = 22; i < 33; i++)
      chk(lg[i] == EXP[i], $sformatf("R6 poll frame %0d", i), lg[i], EXP[i]);
    chk((lt[22] - lt[21] >= POLL) && (lt[22] - lt[21] <= POLL + 10),
        "R6 poll period", lt[22] - lt[21], POLL);
    chk(f_sb == 4'b0001, "R8 short to battery", f_sb, 1);
    chk(f_ot == 4'b1010, "R8 overtemperature", f_ot, 10);
    chk(f_ol == 4'b0110, "R8 overload", f_ol, 6);
    chk(f_op == 4'b1001, "R9 open load", f_op, 9);
    chk(f_sg == 4'b0010, "R9 short to ground", f_sg, 2);
    wait_frames(44);
    chk({f_sb, f_ot, f_ol, f_op, f_sg} == '0, "R5 registers cleared by pass",
        {f_sb, f_ot, f_ol, f_op, f_sg}, 0);

    // R7 power-on reset event, then watchdog event
    mregs[7] = 8'h81;
    wait_frames(75);
    chk(por_cnt == 1 && wdg_cnt == 0, "R7 por counted", {por_cnt, wdg_cnt}, 16'h0100);
    chk(lg[55] == 13'h110F, "R7 reinit starts at config write", lg[55], 13'h110F);
    chk(mregs[7] == 8'h80 && state == 2'd2, "R7 status rewritten, ready kept",
        {mregs[7], 6'd0, state}, 16'h8002);
    mregs[7] = 8'h84;
    wait_frames(106);
    chk(wdg_cnt == 1 && por_cnt == 1, "R7 watchdog counted", {por_cnt, wdg_cnt}, 16'h0101);

    // R11 error while ready
    inj = 1'b1;
    wait_frames(107);
    repeat (4) @(negedge clk);
    chk(err_cnt == 1 && state == 2'd2, "R11 error counted, ready kept", {err_cnt, 6'd0, state}, 16'h0102);
    wait_frames(118);
    chk(lg[107] == 13'h0400 && state == 2'd2, "R11 next poll restarts diag", lg[107], 13'h0400);
    chk(err_cnt == 1, "R11 single error", err_cnt, 1);

    // R10 error during init
    do_reset();
    mregs[8] = 8'hB1;
    pulse_start();
    while (nfr < 5) @(negedge clk);
    inj = 1'b1;
    repeat (10) @(negedge clk);
    chk(state == 2'd3 && !drv_en, "R10 init error fails", {state, drv_en}, 6);
    base = nfr;
    pulse_start();
    repeat (100) @(negedge clk);
    chk(nfr == base && state == 2'd3, "R10 failed ignores start", nfr, base);

    // R3 wrong identity value
    do_reset();
    mregs[8] = 8'hB2;
    pulse_start();
    wait_frames(2);
    repeat (20) @(negedge clk);
    chk(state == 2'd3, "R3 wrong id fails", state, 3);
    chk(nfr == 2 && !drv_en, "R3 no frames after id fail", nfr, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule